// File: doc/BRIEF.md
# Oversampled Receive Clock and Data Recovery

This block rebuilds a bit clock and retimed data from the two comparator outputs of an alternate-mark-inversion line receiver. One input goes high for marks of positive polarity and the other for marks of negative polarity. The block runs from a crystal-derived sampling clock at thirteen times the nominal bit rate, so each recovered bit period is made of thirteen phase slots, numbered 0 to 12. Slot 0 is the slot in which the recovered clock rises.

A mark whose leading edge does not fall in slot 0 shows that the recovered phase is off. The block then nudges the slot counter by one slot: it repeats a slot to retard, or skips a slot to advance. It makes at most one such correction per bit period, so the recovered clock never jumps. With no marks the counter keeps running at the nominal period and holds the last phase. A clock-edge select input decides on which recovered clock edge the retimed data outputs change. The other edge then falls in the middle of a stable data bit.

Top module: `rx_clk_recover`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, that edge sets `rpos_o` and `rneg_o` to 0, sets `rclk_o` to 1, and restarts the slot counter at slot 0. With no marks after reset, `rclk_o` first rises on the 13th edge after the last reset edge.
- R2: With no marks, `rclk_o` is high for 7 sampling cycles (slots 0 to 6) and low for 6 cycles (slots 7 to 12), repeating every 13 cycles.
- R3: A leading edge (a cycle in which `pos_i | neg_i` is 1 after a cycle in which it was 0) sampled in slot 0 leaves the phase unchanged.
- R4: A leading edge sampled in slots 1 to 6 repeats that slot once, which lengthens the current bit period by one cycle.
- R5: A leading edge sampled in slots 7 to 12 skips one slot (the counter advances by two, modulo 13), which shortens the bit period by one cycle.
- R6: At most one correction is made per bit period. A further leading edge in the same period has no effect on the phase.
- R7: When marks stop, the counter free-runs with a 13-cycle period from the phase that was reached last.
- R8: With `clke_i` = 1, `rpos_o` and `rneg_o` change only on the edge that makes `rclk_o` rise. Each then shows whether its input was high in any cycle from slot 12 of the previous period through slot 11 of the period that just ended.
- R9: With `clke_i` = 0, the outputs change only on the edge that makes `rclk_o` fall. Each shows whether its input was high from slot 6 of the previous period through slot 5 of the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, 13 times the nominal bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| pos_i | input | 1 | Comparator output for positive marks, synchronous to `clk` |
| neg_i | input | 1 | Comparator output for negative marks, synchronous to `clk` |
| clke_i | input | 1 | Data edge select: 1 = change on `rclk_o` rise, 0 = change on fall |
| rclk_o | output | 1 | Recovered bit clock |
| rpos_o | output | 1 | Retimed positive-mark data |
| rneg_o | output | 1 | Retimed negative-mark data |

## Verification
Marks aligned to slot 0 are sent as byte patterns in both edge-select modes. Sampling each data bit at the first and last cycle of its expected window tells the rising-edge update apart from the falling-edge update, and keeps the two legs apart. Trains of marks whose leading edges start in slot 3 and in slot 10 show retard and advance separately, through the exact list of recovered clock rise times. An extra edge inside the first corrected period must leave that list unchanged, and a silent tail shows that the reached phase is kept. A reset taken while a data output is high, and a run with no marks at all, pin down the reset state and the nominal duty cycle.

// File: rtl/rx_clk_recover_pkg.sv
// Package: shared constants and types of the receive clock recovery block.
// Assumes the sampling clock is an integer multiple of the bit rate.
package rx_clk_recover_pkg;

    // Default number of sampling slots per bit period.
    localparam int DEF_SLOTS = 13;
    // Default number of slots for which the recovered clock is high.
    localparam int DEF_HIGH_SLOTS = 7;
    // Number of line legs (positive and negative marks).
    localparam int NUM_LEGS = 2;

    // Phase correction chosen for the current sampling cycle.
    typedef enum logic [1:0] {
        CORR_NONE = 2'd0,
        CORR_HOLD = 2'd1,
        CORR_SKIP = 2'd2
    } corr_e;

endpackage

// File: rtl/rx_mark_edge.sv
// Module: finds the leading edge of a mark on either leg.
// Assumes the leg inputs are already synchronous to clk.
module rx_mark_edge #(
    parameter int LEGS = rx_clk_recover_pkg::NUM_LEGS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LEGS-1:0] marks_i,
    output logic            lead_o
);

    logic any_mark;
    logic any_mark_q;

    // Purpose: merge the legs into one mark indication.
    always_comb begin
        any_mark = |marks_i;
    end

    // Purpose: remember last cycle's mark state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_mark_q <= 1'b0;
        end else begin
            any_mark_q <= any_mark;
        end
    end

    // Purpose: flag a mark that was absent in the previous cycle.
    always_comb begin
        lead_o = any_mark & ~any_mark_q;
    end

endmodule

// File: rtl/rx_phase_track.sv
// Module: slot counter with one-slot-per-period phase correction, and the
// recovered clock derived from it. Assumes SLOTS >= 4 and
// 1 < HIGH_SLOTS < SLOTS.
module rx_phase_track
    import rx_clk_recover_pkg::*;
#(
    parameter int SLOTS      = DEF_SLOTS,
    parameter int HIGH_SLOTS = DEF_HIGH_SLOTS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lead_i,
    output logic rclk_o,
    output logic rise_o,
    output logic fall_o
);

    localparam int CW = $clog2(SLOTS);
    localparam logic [CW-1:0] LAST     = CW'(SLOTS - 1);
    localparam logic [CW-1:0] PRE_LAST = CW'(SLOTS - 2);
    localparam logic [CW-1:0] LATE_MAX = CW'((SLOTS - 1) / 2);
    localparam logic [CW-1:0] HIGH_END = CW'(HIGH_SLOTS);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_plus1;
    logic [CW-1:0] cnt_plus2;
    logic [CW-1:0] cnt_nxt;
    logic          adj_q;
    logic          adj_nxt;
    logic          wrap;
    logic          rclk_q;
    logic          rclk_nxt;
    corr_e         corr;

    // Purpose: next slot values for a normal step and for a skip.
    always_comb begin
        cnt_plus1 = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        cnt_plus2 = (cnt_q >= PRE_LAST) ? cnt_q - PRE_LAST : cnt_q + CW'(2);
    end

    // Purpose: choose the correction from the slot a leading edge hit.
    always_comb begin
        corr = CORR_NONE;
        if (lead_i && !adj_q && cnt_q != '0) begin
            corr = (cnt_q <= LATE_MAX) ? CORR_HOLD : CORR_SKIP;
        end
    end

    // Purpose: apply the correction and detect the start of a new period.
    always_comb begin
        unique case (corr)
            CORR_HOLD: cnt_nxt = cnt_q;
            CORR_SKIP: cnt_nxt = cnt_plus2;
            default:   cnt_nxt = cnt_plus1;
        endcase
        wrap     = cnt_nxt < cnt_q;
        adj_nxt  = wrap ? 1'b0 : (adj_q | (corr != CORR_NONE));
        rclk_nxt = cnt_nxt < HIGH_END;
        rise_o   = rclk_nxt & ~rclk_q;
        fall_o   = ~rclk_nxt & rclk_q;
    end

    // Purpose: slot counter, per-period correction flag and clock register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            adj_q  <= 1'b0;
            rclk_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_nxt;
            adj_q  <= adj_nxt;
            rclk_q <= rclk_nxt;
        end
    end

    // Purpose: drive the recovered clock from its register.
    always_comb begin
        rclk_o = rclk_q;
    end

endmodule

// File: rtl/rx_bit_retime.sv
// Module: collects marks per leg over one bit window and presents them on
// the selected recovered clock edge. Assumes rise_i/fall_i are one-cycle
// strobes that coincide with the recovered clock register's update.
module rx_bit_retime #(
    parameter int LEGS = rx_clk_recover_pkg::NUM_LEGS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clke_i,
    input  logic            rise_i,
    input  logic            fall_i,
    input  logic [LEGS-1:0] marks_i,
    output logic [LEGS-1:0] data_o
);

    logic update;

    // Purpose: pick the recovered clock edge that refreshes the data.
    always_comb begin
        update = clke_i ? rise_i : fall_i;
    end

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        logic acc_q;
        logic out_q;

        // Purpose: gather this leg's marks and hand them over at the update edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q <= 1'b0;
                out_q <= 1'b0;
            end else if (update) begin
                acc_q <= marks_i[g];
                out_q <= acc_q;
            end else begin
                acc_q <= acc_q | marks_i[g];
            end
        end

        // Purpose: drive this leg's retimed output.
        always_comb begin
            data_o[g] = out_q;
        end
    end

endmodule

// File: rtl/rx_clk_recover.sv
// Module: top of the oversampled receive clock and data recovery.
// Assumes pos_i/neg_i come from synchronised comparators and clke_i is
// static or changes rarely.
module rx_clk_recover
    import rx_clk_recover_pkg::*;
#(
    parameter int SLOTS      = DEF_SLOTS,
    parameter int HIGH_SLOTS = DEF_HIGH_SLOTS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_i,
    input  logic neg_i,
    input  logic clke_i,
    output logic rclk_o,
    output logic rpos_o,
    output logic rneg_o
);

    logic [NUM_LEGS-1:0] marks;
    logic [NUM_LEGS-1:0] data;
    logic                lead;
    logic                rise;
    logic                fall;

    // Purpose: pack the two legs, positive in bit 0.
    always_comb begin
        marks = {neg_i, pos_i};
    end

    rx_mark_edge #(.LEGS(NUM_LEGS)) edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .marks_i (marks),
        .lead_o  (lead)
    );

    rx_phase_track #(.SLOTS(SLOTS), .HIGH_SLOTS(HIGH_SLOTS)) track_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lead_i (lead),
        .rclk_o (rclk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    rx_bit_retime #(.LEGS(NUM_LEGS)) retime_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clke_i  (clke_i),
        .rise_i  (rise),
        .fall_i  (fall),
        .marks_i (marks),
        .data_o  (data)
    );

    // Purpose: unpack the retimed legs.
    always_comb begin
        rpos_o = data[0];
        rneg_o = data[1];
    end

endmodule

// File: rtl/rx_clk_recover_chk.sv
// Module: checker bound to rx_clk_recover; watches only its ports.
// Assumes reset is held for at least two clock edges.
module rx_clk_recover_chk #(
    parameter int SLOTS      = rx_clk_recover_pkg::DEF_SLOTS,
    parameter int HIGH_SLOTS = rx_clk_recover_pkg::DEF_HIGH_SLOTS
) (
    input logic clk,
    input logic rst_n,
    input logic pos_i,
    input logic neg_i,
    input logic clke_i,
    input logic rclk_o,
    input logic rpos_o,
    input logic rneg_o
);

    localparam int LOW_SLOTS = SLOTS - HIGH_SLOTS;

    logic [7:0] run_q;
    logic       rclk_d;
    logic       unused_in;

    // Purpose: mark the leg inputs as intentionally unobserved.
    always_comb begin
        unused_in = pos_i ^ neg_i;
    end

    // Purpose: count how long the recovered clock has held its level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 8'd0;
            rclk_d <= 1'b1;
        end else begin
            rclk_d <= rclk_o;
            if (rclk_o != rclk_d) begin
                run_q <= 8'd1;
            end else if (run_q != 8'hFF) begin
                run_q <= run_q + 8'd1;
            end
        end
    end

    // R1: reset edge clears the data and raises the clock.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!rpos_o && !rneg_o && rclk_o));

    // R6: a high phase is stretched or cut by at most one slot.
    assert_high_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rclk_o) |-> (run_q >= 8'(HIGH_SLOTS - 1) && run_q <= 8'(HIGH_SLOTS + 1)));

    // R6: a low phase is stretched or cut by at most one slot.
    assert_low_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rclk_o) |-> (run_q >= 8'(LOW_SLOTS - 1) && run_q <= 8'(LOW_SLOTS + 1)));

    // R8 / R9: data moves only on the recovered clock edge the select names.
    assert_data_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rpos_o != $past(rpos_o)) || (rneg_o != $past(rneg_o)))
        |-> ($past(clke_i) ? $rose(rclk_o) : $fell(rclk_o)));

endmodule

bind rx_clk_recover rx_clk_recover_chk #(
    .SLOTS      (SLOTS),
    .HIGH_SLOTS (HIGH_SLOTS)
) chk_i (.*);

// File: tb/rx_clk_recover_tb_top.sv
// Bench: vector table of mark patterns in both edge modes, then directed
// tests for reset, free-running, retard, advance and the per-period limit.
module rx_clk_recover_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int VEC_N = 4;
    // {clke, positive marks per bit (bit 0 first), negative marks per bit}
    localparam logic [16:0] VEC [0:VEC_N-1] = '{
        {1'b1, 8'b0100_1001, 8'b1001_0100},
        {1'b0, 8'b0100_1001, 8'b1001_0100},
        {1'b1, 8'b1111_1111, 8'b0000_0000},
        {1'b0, 8'b0000_0000, 8'b0011_0110}
    };

    logic clk;
    logic rst_n;
    logic pos_i;
    logic neg_i;
    logic clke_i;
    logic rclk_o;
    logic rpos_o;
    logic rneg_o;

    int n_checks;
    int n_fails;
    int n;
    int rise_t [0:15];
    int nrise;
    logic rclk_prev;

    rx_clk_recover dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pos_i  (pos_i),
        .neg_i  (neg_i),
        .clke_i (clke_i),
        .rclk_o (rclk_o),
        .rpos_o (rpos_o),
        .rneg_o (rneg_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, n);
        end
    endtask

    // One sampling cycle: drive at the falling edge, sample at the next one.
    task automatic step(input logic p, input logic q);
        pos_i = p;
        neg_i = q;
        @(negedge clk);
        n++;
        if (rclk_o && !rclk_prev && nrise < 16) begin
            rise_t[nrise] = n;
            nrise++;
        end
        rclk_prev = rclk_o;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pos_i = 1'b0;
        neg_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 rpos", rpos_o, 0);
        check("R1 rneg", rneg_o, 0);
        check("R1 rclk", rclk_o, 1);
        rst_n = 1'b1;
        n = 0;
        nrise = 0;
        rclk_prev = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        n_checks = 0;
        n_fails = 0;
        n = 0;
        nrise = 0;
        rclk_prev = 1'b1;
        clke_i = 1'b1;
        rst_n = 1'b0;
        pos_i = 1'b0;
        neg_i = 1'b0;
        @(negedge clk);

        // Table walk: aligned marks, data windows in both edge modes (R3, R8, R9).
        for (int v = 0; v < VEC_N; v++) begin
            logic [7:0] pv;
            logic [7:0] nv;
            int s;
            clke_i = VEC[v][16];
            pv = VEC[v][15:8];
            nv = VEC[v][7:0];
            s = clke_i ? 13 : 7;
            do_reset();
            for (int k = 1; k <= 117; k++) begin
                int b;
                int sl;
                int r;
                b = (k - 1) / 13;
                sl = (k - 1) % 13;
                step((b < 8 && sl < 6) ? pv[b] : 1'b0, (b < 8 && sl < 6) ? nv[b] : 1'b0);
                r = k - s;
                if (r >= 0 && (r % 13 == 0 || r % 13 == 12) && r / 13 < 8) begin
                    check(clke_i ? "R8 rpos" : "R9 rpos", rpos_o, pv[r / 13]);
                    check(clke_i ? "R8 rneg" : "R9 rneg", rneg_o, nv[r / 13]);
                end
                if (k % 13 == 0 || k % 13 == 6) check("R2 rclk high", rclk_o, 1);
                if (k % 13 == 7 || k % 13 == 12) check("R2 rclk low", rclk_o, 0);
            end
            check("R3 rise count", nrise, 9);
            check("R3 last rise", rise_t[8], 117);
        end

        // R2 / R1: free-running after reset with no marks.
        clke_i = 1'b1;
        do_reset();
        for (int k = 1; k <= 40; k++) begin
            step(1'b0, 1'b0);
            if (k == 6 || k == 19) check("R2 high before fall", rclk_o, 1);
            if (k == 7 || k == 20) check("R2 fell", rclk_o, 0);
            if (k == 12) check("R1 low before first rise", rclk_o, 0);
        end
        check("R1 first rise", rise_t[0], 13);
        check("R2 second rise", rise_t[1], 26);
        check("R2 third rise", rise_t[2], 39);

        // R4 / R6 / R7: marks starting in slot 3, extra edge in slot 7 of first period.
        do_reset();
        for (int k = 1; k <= 100; k++) begin
            logic p;
            p = (k <= 52) && ((k - 1) % 13 >= 3) && ((k - 1) % 13 <= 5);
            if (k >= 9 && k <= 11) p = 1'b1;
            step(p, 1'b0);
        end
        check("R4 rise 0", rise_t[0], 14);
        check("R6 rise 0 ignores second edge", rise_t[0] != 13, 1);
        check("R4 rise 1", rise_t[1], 28);
        check("R4 rise 2", rise_t[2], 42);
        check("R4 rise 3 aligned", rise_t[3], 55);
        check("R7 rise 4", rise_t[4], 68);
        check("R7 rise 5", rise_t[5], 81);
        check("R7 rise 6", rise_t[6], 94);

        // R5: marks on the negative leg starting in slot 10.
        do_reset();
        for (int k = 1; k <= 90; k++) begin
            logic q;
            q = (k <= 52) && ((k - 1) % 13 >= 10);
            step(1'b0, q);
        end
        check("R5 rise 0", rise_t[0], 12);
        check("R5 rise 1", rise_t[1], 24);
        check("R5 rise 2", rise_t[2], 37);
        check("R5 rise 3", rise_t[3], 49);
        check("R7 rise 4", rise_t[4], 62);
        check("R7 rise 5", rise_t[5], 75);
        check("R7 rise 6", rise_t[6], 88);

        // R1: reset taken while a data output is high.
        clke_i = 1'b1;
        do_reset();
        for (int k = 1; k <= 20; k++) begin
            step(((k - 1) % 13) < 6, 1'b0);
        end
        check("R8 rpos high before reset", rpos_o, 1);
        do_reset();
        for (int k = 1; k <= 13; k++) step(1'b0, 1'b0);
        check("R1 rise after mid-run reset", rise_t[0], 13);
        check("R1 rpos after mid-run reset", rpos_o, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule